// File: doc/BRIEF.md
# Turbo Code Bit Grouping Output Sequencer

This block takes six subblocks of a turbo-coded word that have already been permuted by the subblock interleaver: the systematic pair A and B and the parity streams Y1, Y2, W1 and W2. It serialises them into one codeword stream. Software-side or upstream logic first fills six internal one-bit-wide buffers through a write port. Each write carries a subblock select, an address and one data bit. The subblock length N is set per run, from 1 up to the parameter `MAX_N`. For example, 48 information bits give N = 24.

A start pulse latches N and the ordering mode. The block then emits 6N bits, one per accepted handshake, with a valid/ready pair on the output side. A done flag marks the final bit. The sequence is all of A, then all of B, then Y1 and Y2 taken alternately bit by bit, then W1 and W2 taken the same way.

In the rotated ordering, B is read starting one position later and wraps around, so its first bit comes out last. In the legacy ordering, B comes out in natural order.

Top module: `ctc_grp_seq`

## Requirements
- R1: A synchronous active-high reset, whether applied at power-up or in the middle of a run, leaves `out_valid` and `out_done` low from the next clock edge and discards any run in progress.
- R2: A write with `wr_en` high stores `wr_data` at `wr_addr` of the subblock chosen by `wr_sel`, coded 0=A, 1=B, 2=Y1, 3=Y2, 4=W1, 5=W2. Writes with codes 6 or 7 change no buffer.
- R3: The first N output bits of a run are A[0] through A[N-1] in index order.
- R4: With `rot_en` high at start, output bits N to 2N-1 are B[1], B[2], ..., B[N-1], B[0].
- R5: With `rot_en` low at start, output bits N to 2N-1 are B[0] through B[N-1].
- R6: Output bits 2N to 4N-1 are Y1[0], Y2[0], Y1[1], Y2[1], ..., Y1[N-1], Y2[N-1].
- R7: Output bits 4N to 6N-1 are W1[0], W2[0], W1[1], W2[1], ..., W1[N-1], W2[N-1].
- R8: A run delivers exactly 6N bits. `out_done` is high together with `out_valid` only on the last bit, and `out_valid` falls in the cycle after that bit is accepted.
- R9: While `out_valid` is high and `out_ready` is low, `out_bit`, `out_done` and the position in the sequence stay unchanged.
- R10: A start pulse is ignored while a run is in progress, and also when `blk_len` is 0 or greater than `MAX_N`.
- R11: With N = 1 and the rotated ordering, the B portion is the single bit B[0].
- R12: An accepted start raises `out_valid` in the following cycle. `blk_len` and `rot_en` are sampled only at that start, so changes to them during a run have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Buffer write strobe |
| wr_sel | input | 3 | Subblock select for the write (0=A, 1=B, 2=Y1, 3=Y2, 4=W1, 5=W2) |
| wr_addr | input | $clog2(MAX_N) | Bit index within the selected subblock |
| wr_data | input | 1 | Bit to store |
| blk_len | input | $clog2(MAX_N+1) | Subblock length N, sampled at start |
| rot_en | input | 1 | 1 = B rotated left by one, 0 = B in natural order; sampled at start |
| start | input | 1 | One-cycle pulse that begins a run |
| out_ready | input | 1 | Downstream accepts the current bit |
| out_valid | output | 1 | A codeword bit is presented |
| out_bit | output | 1 | Current codeword bit |
| out_done | output | 1 | Current bit is the last one of the run |

## Verification
The reference model rebuilds the full expected stream from its own copy of the buffers and compares it on every cycle. Runs use N = 24, N = 1, N = 7 and N = `MAX_N`. Random buffer contents make an A/B swap, a rotation in the wrong direction or a Y/W phase inversion show up at once. Running the same contents in both orderings separates the rotated B read from the natural one. N = 1 and N = `MAX_N` exercise the wrap address at both extremes. Three handshake patterns are used: `out_ready` always high, random and mostly low. Together they show that back-pressure freezes the bit and the position. Mid-run start pulses, out-of-range lengths, writes with unused select codes and a reset during a run check that these leave the stream untouched or end it cleanly.

// File: rtl/ctc_grp_pkg.sv
package ctc_grp_pkg;

  // Position of the sequencer within the grouped codeword
  typedef enum logic [1:0] {
    PH_A = 2'd0,
    PH_B = 2'd1,
    PH_Y = 2'd2,
    PH_W = 2'd3
  } phase_e;

  localparam int NUM_SUB = 6;

  // Subblock select codes on the write port and read mux
  localparam logic [2:0] SEL_A  = 3'd0;
  localparam logic [2:0] SEL_B  = 3'd1;
  localparam logic [2:0] SEL_Y1 = 3'd2;
  localparam logic [2:0] SEL_Y2 = 3'd3;
  localparam logic [2:0] SEL_W1 = 3'd4;
  localparam logic [2:0] SEL_W2 = 3'd5;

endpackage

// File: rtl/ctc_grp_bitmem.sv
// One-bit-wide simple dual-port buffer with registered read (block RAM style)
module ctc_grp_bitmem #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wdata,
  input  logic [AW-1:0] raddr,
  output logic          rdata
);

  logic store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      store[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    rdata <= store[raddr];
  end

endmodule

// File: rtl/ctc_grp_walk.sv
// Sequence walker: tracks phase and index, computes the look-ahead read
// address so the registered buffers present the next bit with no bubble.
module ctc_grp_walk
  import ctc_grp_pkg::*;
#(
  parameter int MAX_N = 64,
  parameter int AW    = $clog2(MAX_N),
  parameter int LW    = $clog2(MAX_N + 1),
  parameter int KW    = $clog2(2 * MAX_N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [LW-1:0] len,
  input  logic          rot,
  input  logic          ready,
  output logic          busy,
  output logic          done,
  output logic [2:0]    sel,
  output logic [AW-1:0] rd_addr
);

  localparam int CW = KW + 1;

  logic          busy_q, busy_n;
  logic          done_q, done_n;
  logic [2:0]    sel_q, sel_n;
  phase_e        ph_q, ph_n;
  logic [KW-1:0] k_q, k_n;
  logic [LW-1:0] len_q, len_n;
  logic          rot_q, rot_n;

  logic          len_ok, accept, fire, at_end, b_wrap;
  logic [CW-1:0] ab_end, yw_end, end_k;

  assign len_ok = (len != '0) && (CW'(len) <= CW'(MAX_N));
  assign accept = start && !busy_q && len_ok;
  assign fire   = busy_q && ready;
  assign len_n  = accept ? len : len_q;
  assign rot_n  = accept ? rot : rot_q;

  assign ab_end = CW'(len_q) - CW'(1);
  assign yw_end = (CW'(len_q) << 1) - CW'(1);
  assign end_k  = ph_q[1] ? yw_end : ab_end;
  assign at_end = (CW'(k_q) == end_k);

  // Next position in the codeword
  always_comb begin
    busy_n = busy_q;
    ph_n   = ph_q;
    k_n    = k_q;
    if (accept) begin
      busy_n = 1'b1;
      ph_n   = PH_A;
      k_n    = '0;
    end else if (fire) begin
      if (done_q) begin
        busy_n = 1'b0;
      end else if (at_end) begin
        ph_n = phase_e'(ph_q + 2'd1);
        k_n  = '0;
      end else begin
        k_n = k_q + KW'(1);
      end
    end
  end

  // Read address and subblock for the next position
  assign b_wrap = (CW'(k_n) == (CW'(len_n) - CW'(1)));

  always_comb begin
    rd_addr = AW'(k_n);
    sel_n   = SEL_A;
    unique case (ph_n)
      PH_A: begin
        rd_addr = AW'(k_n);
        sel_n   = SEL_A;
      end
      PH_B: begin
        sel_n = SEL_B;
        if (!rot_n)      rd_addr = AW'(k_n);
        else if (b_wrap) rd_addr = '0;
        else             rd_addr = AW'(k_n + KW'(1));
      end
      PH_Y: begin
        rd_addr = AW'(k_n >> 1);
        sel_n   = k_n[0] ? SEL_Y2 : SEL_Y1;
      end
      PH_W: begin
        rd_addr = AW'(k_n >> 1);
        sel_n   = k_n[0] ? SEL_W2 : SEL_W1;
      end
      default: ;
    endcase
  end

  assign done_n = busy_n && (ph_n == PH_W) &&
                  (CW'(k_n) == ((CW'(len_n) << 1) - CW'(1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sel_q  <= SEL_A;
      ph_q   <= PH_A;
      k_q    <= '0;
      len_q  <= '0;
      rot_q  <= 1'b0;
    end else begin
      busy_q <= busy_n;
      done_q <= done_n;
      sel_q  <= sel_n;
      ph_q   <= ph_n;
      k_q    <= k_n;
      len_q  <= len_n;
      rot_q  <= rot_n;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign sel  = sel_q;

endmodule

// File: rtl/ctc_grp_seq.sv
// Bit grouping output sequencer: six subblock buffers feeding one serial stream
module ctc_grp_seq
  import ctc_grp_pkg::*;
#(
  parameter int MAX_N = 64,
  parameter int AW    = $clog2(MAX_N),
  parameter int LW    = $clog2(MAX_N + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_data,
  input  logic [LW-1:0] blk_len,
  input  logic          rot_en,
  input  logic          start,
  input  logic          out_ready,
  output logic          out_valid,
  output logic          out_bit,
  output logic          out_done
);

  localparam int KW = $clog2(2 * MAX_N);

  logic [AW-1:0] rd_addr;
  logic [2:0]    cur_sel;
  logic [7:0]    rd_bits;

  ctc_grp_walk #(
    .MAX_N (MAX_N),
    .AW    (AW),
    .LW    (LW),
    .KW    (KW)
  ) u_walk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .len     (blk_len),
    .rot     (rot_en),
    .ready   (out_ready),
    .busy    (out_valid),
    .done    (out_done),
    .sel     (cur_sel),
    .rd_addr (rd_addr)
  );

  for (genvar g = 0; g < NUM_SUB; g++) begin : g_sub
    ctc_grp_bitmem #(
      .DEPTH (MAX_N),
      .AW    (AW)
    ) u_mem (
      .clk   (clk),
      .we    (wr_en && (wr_sel == 3'(g))),
      .waddr (wr_addr),
      .wdata (wr_data),
      .raddr (rd_addr),
      .rdata (rd_bits[g])
    );
  end

  assign rd_bits[7:NUM_SUB] = '0;
  assign out_bit = rd_bits[cur_sel];

endmodule

// File: rtl/ctc_grp_seq_chk.sv
// Property checker for ctc_grp_seq, attached by bind
module ctc_grp_seq_chk #(
  parameter int MAX_N = 64,
  parameter int LW    = $clog2(MAX_N + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [LW-1:0] blk_len,
  input logic          out_ready,
  input logic          out_valid,
  input logic          out_bit,
  input logic          out_done
);

  localparam int BW = $clog2(6 * MAX_N + 1);

  logic [LW-1:0] cap_len;
  logic [BW-1:0] beat_q;

  // Independent beat counter over a run
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_len <= '0;
      beat_q  <= '0;
    end else if (start && !out_valid && blk_len != '0 &&
                 int'(blk_len) <= MAX_N) begin
      cap_len <= blk_len;
      beat_q  <= '0;
    end else if (out_valid && out_ready) begin
      beat_q <= beat_q + BW'(1);
    end
  end

  AST_RST_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !out_done)); // R1

  AST_DONE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    out_done |-> out_valid); // R8

  AST_END_DROPS_VALID: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_done) |=> !out_valid); // R8

  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (rst)
    out_done |-> (beat_q == (BW'(cap_len) * BW'(6)) - BW'(1))); // R8

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit) && $stable(out_done))); // R9

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !(out_ready && out_done)) |=> out_valid); // R10

  AST_VALID_FROM_START: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(start)); // R12

endmodule

bind ctc_grp_seq ctc_grp_seq_chk #(
  .MAX_N (MAX_N),
  .LW    (LW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .blk_len   (blk_len),
  .out_ready (out_ready),
  .out_valid (out_valid),
  .out_bit   (out_bit),
  .out_done  (out_done)
);

// File: tb/ctc_grp_seq_tb_top.sv
`timescale 1ns/1ps
module ctc_grp_seq_tb_top;

  localparam int MAXN = 32;
  localparam int AW   = $clog2(MAXN);
  localparam int LW   = $clog2(MAXN + 1);

  typedef struct {
    bit b;
    int req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_sel = '0;
  logic [AW-1:0] wr_addr = '0;
  logic          wr_data = 1'b0;
  logic [LW-1:0] blk_len = '0;
  logic          rot_en = 1'b0;
  logic          start = 1'b0;
  logic          out_ready = 1'b0;
  logic          out_valid, out_bit, out_done;

  always #4 clk = ~clk;

  ctc_grp_seq #(.MAX_N(MAXN)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
    .wr_data(wr_data), .blk_len(blk_len), .rot_en(rot_en), .start(start),
    .out_ready(out_ready), .out_valid(out_valid), .out_bit(out_bit),
    .out_done(out_done)
  );

  // Bench state
  int   n_chk = 0;
  int   n_bad = 0;
  bit   ref_mem [6][MAXN];
  exp_t q[$];
  bit   rst_d = 1'b1;
  bit   stalled = 1'b0;
  int   tag_ovr = 0;
  int   idle_tag = 12;
  int   rdy_mode = 0;
  int   cyc = 0;

  // Pending stimulus applied at the next step
  bit          s_rst = 1'b1;
  bit          s_start = 1'b0;
  bit          s_wr = 1'b0;
  int          s_sel = 0;
  int          s_addr = 0;
  bit          s_data = 1'b0;
  int          s_len = 0;
  bit          s_rot = 1'b0;

  task automatic check(input bit ok, input int req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %0d expected %0d (cycle %0d)",
               req, what, act, exp, cyc);
    end
  endtask

  function automatic void push_run(input int n, input bit rot);
    for (int i = 0; i < n; i++) q.push_back('{ref_mem[0][i], 3});          // R3
    for (int i = 0; i < n; i++) begin
      if (rot) q.push_back('{ref_mem[1][(i + 1) % n], (n == 1) ? 11 : 4});  // R4, R11
      else     q.push_back('{ref_mem[1][i], 5});                            // R5
    end
    for (int i = 0; i < n; i++) begin                                       // R6
      q.push_back('{ref_mem[2][i], 6});
      q.push_back('{ref_mem[3][i], 6});
    end
    for (int i = 0; i < n; i++) begin                                       // R7
      q.push_back('{ref_mem[4][i], 7});
      q.push_back('{ref_mem[5][i], 7});
    end
  endfunction

  // One cycle: compare at the falling edge, then drive and update the model
  task automatic step();
    bit was_empty;
    bit rdy;
    int tg;
    @(negedge clk);
    cyc++;
    if (q.size() == 0) begin
      tg = rst_d ? 1 : idle_tag;
      check(out_valid == 1'b0, tg, "valid while idle", int'(out_valid), 0);
      check(out_done == 1'b0, tg, "done while idle", int'(out_done), 0);
    end else begin
      tg = (tag_ovr != 0) ? tag_ovr : (stalled ? 9 : q[0].req);
      check(out_valid == 1'b1, 12, "valid during run", int'(out_valid), 1);
      check(out_bit == q[0].b, tg, "stream bit", int'(out_bit), int'(q[0].b));
      check(out_done == (q.size() == 1), 8, "done flag", int'(out_done),
            int'(q.size() == 1));
    end
    case (rdy_mode)
      0:       rdy = 1'b1;
      1:       rdy = ($urandom % 2) == 0;
      default: rdy = (cyc % 4) == 0;
    endcase
    rst       = s_rst;
    start     = s_start;
    wr_en     = s_wr;
    wr_sel    = 3'(s_sel);
    wr_addr   = AW'(s_addr);
    wr_data   = s_data;
    blk_len   = LW'(s_len);
    rot_en    = s_rot;
    out_ready = rdy;
    if (s_rst) begin
      q.delete();
    end else begin
      was_empty = (q.size() == 0);
      if (s_wr && s_sel < 6) ref_mem[s_sel][s_addr] = s_data;  // R2: codes 6,7 ignored
      if (!was_empty && rdy) void'(q.pop_front());
      if (s_start && was_empty && s_len >= 1 && s_len <= MAXN) push_run(s_len, s_rot);
    end
    stalled = (q.size() != 0) && !rdy;
    rst_d   = s_rst;
    s_start = 1'b0;
    s_wr    = 1'b0;
  endtask

  task automatic load(input int n);
    for (int s = 0; s < 6; s++) begin
      for (int a = 0; a < n; a++) begin
        s_wr = 1'b1; s_sel = s; s_addr = a; s_data = 1'($urandom);
        step();
      end
    end
  endtask

  task automatic run(input int n, input bit rot, input int mode);
    int guard;
    rdy_mode = mode;
    s_len = n; s_rot = rot; s_start = 1'b1;
    step();
    guard = 0;
    while (q.size() != 0 && guard < 4000) begin
      step();
      guard++;
    end
    step();
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    s_rst = 1'b1;
    repeat (3) step();
    s_rst = 1'b0;
    repeat (2) step();

    // R3 R4 R6 R7 R8 R12: N = 24 (48 information bits), rotated, ready high
    load(24);
    run(24, 1'b1, 0);
    // R5 R9: same contents, natural B order, random back-pressure
    run(24, 1'b0, 1);

    // R10 R12: start and parameter changes during a run are ignored
    rdy_mode = 1;
    s_len = 24; s_rot = 1'b1; s_start = 1'b1;
    step();
    repeat (15) step();
    s_len = 5; s_rot = 1'b0; s_start = 1'b1;
    step();
    repeat (10) step();
    s_start = 1'b1;
    step();
    while (q.size() != 0) step();
    step();

    // R10: out-of-range lengths do not start a run
    idle_tag = 10;
    s_len = 0; s_start = 1'b1; step();
    repeat (3) step();
    s_len = MAXN + 1; s_start = 1'b1; step();
    repeat (3) step();
    idle_tag = 12;

    // R2: unused select codes leave all buffers untouched
    for (int a = 0; a < 24; a++) begin
      s_wr = 1'b1; s_sel = 6 + (a % 2); s_addr = a; s_data = ~ref_mem[a % 6][a];
      step();
    end
    tag_ovr = 2;
    run(24, 1'b1, 2);
    tag_ovr = 0;

    // R11: single-bit subblocks
    load(1);
    run(1, 1'b1, 0);
    run(1, 1'b0, 1);

    // R4: largest length exercises the wrap at the top address
    load(MAXN);
    run(MAXN, 1'b1, 1);

    // R1: reset in the middle of a run
    load(7);
    rdy_mode = 0;
    s_len = 7; s_rot = 1'b1; s_start = 1'b1;
    step();
    repeat (12) step();
    s_rst = 1'b1;
    repeat (2) step();
    s_rst = 1'b0;
    repeat (2) step();
    run(7, 1'b1, 2);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule